// File: doc/BRIEF.md
# Retriggerable Programmable Delay One-Shot

This block is the control logic of a digital monostable. A rising edge on trigger input `trig_a` or a falling edge on trigger input `trig_b` starts an output pulse. Tie the two inputs together and either edge direction starts it. While the pulse runs, `q` is high and `q_n` is low. An external delay counter, clocked by a timebase oscillator, times the pulse. The block holds that counter cleared through `cnt_clr` and ends the pulse when the counter reports its terminal count on `cnt_tc`. The pulse width is therefore the counter's division ratio divided by the timebase frequency.

Retriggering is selectable:
- With `retrig_en` high, a new trigger edge during a pulse restarts the count, so the pulse can be stretched indefinitely.
- With `retrig_en` low, trigger edges during a pulse are ignored.

The timebase enable `osc_en` is controlled by `osc_free`:
- With `osc_free` high, the oscillator runs all the time.
- With `osc_free` low, the oscillator is enabled only while a pulse is being timed.

A master reset (`mreset`) and a power-on reset (`por_n`) clear the block asynchronously. Their release is synchronised to `clk`. Both trigger inputs are synchronised into `clk` with two flops before edge detection. The counter handshake (`cnt_clr` and `cnt_tc`) is treated as synchronous to `clk`.

Top module: `delay_oneshot`

## Requirements
- R1: A rising edge on `trig_a` while idle sets `q` high. If `trig_a` is driven at a falling `clk` edge, `q` rises on the third following rising `clk` edge.
- R2: A falling edge on `trig_b` while idle starts a pulse with the same latency as R1.
- R3: `q_n` is always the complement of `q`. When idle, `q` is 0 and `q_n` is 1.
- R4: While idle, `cnt_clr` is held at 1. During a pulse it is 0, except for a restart. When `cnt_tc` is 1 during a pulse and there is no restart, `q` falls at the next rising edge and `cnt_clr` returns to 1. While idle, `cnt_tc` is ignored.
- R5: With `retrig_en` = 0, trigger edges during a pulse change neither `q` nor `cnt_clr`.
- R6: With `retrig_en` = 1, a trigger edge during a pulse keeps `q` high and pulses `cnt_clr` high for exactly one cycle. This holds even when `cnt_tc` is 1 in the same cycle.
- R7: `osc_en` is 1 whenever `osc_free` = 1. With `osc_free` = 0, `osc_en` follows `q`.
- R8: `mreset` = 1 forces `q` to 0, `q_n` to 1 and `cnt_clr` to 1 at once, without a clock edge, ending any pulse.
- R9: `por_n` = 0 has the same effect as `mreset` = 1.
- R10: Reset is released two rising edges after both reset inputs deassert. Trigger synchroniser stages clear to 0, so a `trig_a` held at 1 across the release counts as a rising edge: `q` rises on the fifth rising edge after the release, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| mreset | input | 1 | Asynchronous master reset, active high |
| por_n | input | 1 | Power-on reset, active low |
| trig_a | input | 1 | Trigger, rising-edge active |
| trig_b | input | 1 | Trigger, falling-edge active |
| retrig_en | input | 1 | 1: retriggerable, 0: non-retriggerable |
| osc_free | input | 1 | 1: timebase always on, 0: gated by pulse |
| cnt_tc | input | 1 | Terminal count from delay counter |
| q | output | 1 | Pulse output, active high |
| q_n | output | 1 | Complement of `q` |
| cnt_clr | output | 1 | Clear/restart for delay counter |
| osc_en | output | 1 | Timebase oscillator enable |

## Verification
Some behaviours are checked by assertions on every cycle:
- start of a pulse on a detected edge;
- immunity to triggers in non-retriggerable mode;
- the one-cycle restart clear when retriggering;
- termination on terminal count;
- the counter clear held while idle.

Other behaviours can only be shown by the bench's timed scenarios:
- the exact latency from a pin edge to `q`;
- the asynchronous effect of the master and power-on resets between clock edges;
- the two-cycle reset release;
- the oscillator gating as seen at the pins.

// File: rtl/delay_oneshot.sv
module delay_oneshot #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic mreset,
  input  logic por_n,
  input  logic trig_a,
  input  logic trig_b,
  input  logic retrig_en,
  input  logic osc_free,
  input  logic cnt_tc,
  output logic q,
  output logic q_n,
  output logic cnt_clr,
  output logic osc_en
);

  localparam int LAST = SYNC_STAGES - 1;

  logic arst;
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic rst_n;
  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic a_prev, b_prev;
  logic trig, active, restart, active_nx, clr_q;

  assign arst  = mreset | ~por_n;
  assign rst_n = rst_pipe[LAST];

  always_ff @(posedge clk or posedge arst) begin
    if (arst) rst_pipe <= '0;
    else      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      a_sync <= '0;
      b_sync <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], trig_a};
      b_sync <= {b_sync[SYNC_STAGES-2:0], trig_b};
      a_prev <= a_sync[LAST];
      b_prev <= b_sync[LAST];
    end
  end

  assign trig    = (a_sync[LAST] & ~a_prev) | (~b_sync[LAST] & b_prev);
  assign restart = active & retrig_en & trig;

  always_comb begin
    active_nx = active;
    if (!active && trig)                active_nx = 1'b1;
    else if (active && !restart && cnt_tc) active_nx = 1'b0;
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      active <= 1'b0;
      clr_q  <= 1'b1;
    end else if (!rst_n) begin
      active <= 1'b0;
      clr_q  <= 1'b1;
    end else begin
      active <= active_nx;
      clr_q  <= ~active_nx | restart;
    end
  end

  assign q       = active;
  assign q_n     = ~active;
  assign cnt_clr = clr_q;
  assign osc_en  = osc_free | active;

  // R1
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || arst)
    (!q && trig) |=> (q && !cnt_clr));

  // R5
  no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n || arst)
    (q && !retrig_en && !cnt_tc) |=> (q && !cnt_clr));

  // R6
  retrig_restart_chk: assert property (@(posedge clk) disable iff (!rst_n || arst)
    (q && retrig_en && trig) |=> (q && cnt_clr));

  // R4
  tc_end_chk: assert property (@(posedge clk) disable iff (!rst_n || arst)
    (q && cnt_tc && !(retrig_en && trig)) |=> (!q && cnt_clr));

  // R4
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || arst)
    !q |-> cnt_clr);

endmodule

// File: tb/delay_oneshot_tb.sv
module delay_oneshot_tb;
  logic clk = 1'b0;
  logic mreset, por_n, trig_a, trig_b, retrig_en, osc_free, cnt_tc;
  logic q, q_n, cnt_clr, osc_en;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  delay_oneshot u_dut (
    .clk(clk), .mreset(mreset), .por_n(por_n), .trig_a(trig_a), .trig_b(trig_b),
    .retrig_en(retrig_en), .osc_free(osc_free), .cnt_tc(cnt_tc),
    .q(q), .q_n(q_n), .cnt_clr(cnt_clr), .osc_en(osc_en)
  );

  // row bits: a b retrig osc tc | exp q clr osc
  localparam int NROWS = 28;
  localparam logic [7:0] VEC [NROWS] = '{
    8'b10000_010, // R1 edge on A, not yet visible
    8'b10000_010,
    8'b10000_101, // R1 q rises, R7 osc follows q
    8'b00000_101,
    8'b10000_101, // R5 second edge
    8'b10000_101,
    8'b10000_101, // R5 ignored
    8'b00001_010, // R4 tc ends pulse
    8'b01000_010,
    8'b00100_010, // R2 B falls
    8'b00100_010,
    8'b00100_101, // R2 pulse starts
    8'b01100_101,
    8'b01100_101,
    8'b00100_101,
    8'b00100_101,
    8'b00100_111, // R6 restart clear pulse
    8'b01101_010, // R4 end
    8'b01110_011, // R7 free-running oscillator
    8'b11110_011,
    8'b11110_011,
    8'b11111_101, // R4 tc idle ignored, R1 start
    8'b01110_101,
    8'b11110_101,
    8'b11110_101,
    8'b11111_111, // R6 trigger with tc restarts
    8'b11110_101,
    8'b11001_010  // R7 gated again, R4 end
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual q,qn,clr,osc=%b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    mreset = 1'b1; por_n = 1'b0; trig_a = 1'b0; trig_b = 1'b1;
    retrig_en = 1'b0; osc_free = 1'b0; cnt_tc = 1'b0;
    #1;
    chk("R9 por state", {q, q_n, cnt_clr, osc_en}, 4'b0110);
    por_n = 1'b1;
    tick(); tick();
    chk("R8 reset state R3", {q, q_n, cnt_clr, osc_en}, 4'b0110);
    @(negedge clk); mreset = 1'b0;
    repeat (4) tick();

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      {trig_a, trig_b, retrig_en, osc_free, cnt_tc} = VEC[i][7:3];
      tick();
      chk($sformatf("row %0d R1 R2 R3 R4 R5 R6 R7", i),
          {q, q_n, cnt_clr, osc_en},
          {VEC[i][2], ~VEC[i][2], VEC[i][1], VEC[i][0]});
    end

    // R8 asynchronous master reset mid-pulse
    @(negedge clk); {trig_a, cnt_tc} = 2'b00;
    repeat (2) tick();
    @(negedge clk); trig_a = 1'b1;
    repeat (3) tick();
    chk("R8 pulse running", {q, q_n, cnt_clr, osc_en}, 4'b1001);
    #1 mreset = 1'b1;
    #0.5;
    chk("R8 async clear", {q, q_n, cnt_clr, osc_en}, 4'b0110);

    // R10 synchronous release, A held high counts as an edge
    @(negedge clk); mreset = 1'b0;
    repeat (4) tick();
    chk("R10 not before fifth edge", {q, q_n, cnt_clr, osc_en}, 4'b0110);
    tick();
    chk("R10 starts on fifth edge", {q, q_n, cnt_clr, osc_en}, 4'b1001);

    // R9 power-on reset mid-pulse
    #1 por_n = 1'b0;
    #0.5;
    chk("R9 por clears pulse", {q, q_n, cnt_clr, osc_en}, 4'b0110);
    @(negedge clk); por_n = 1'b1; trig_a = 1'b0;
    repeat (4) tick();
    chk("R3 idle after por", {q, q_n, cnt_clr, osc_en}, 4'b0110);

    finish_run();
  end
endmodule